// File: doc/BRIEF.md
# Transmit/Receive Descriptor Ring Controller

This block manages a single table of 128 descriptors, each 64 bits wide, that is divided into a transmit ring and a receive ring. A boundary register N sets the split. Entries below N form the transmit ring and entries from N upward form the receive ring. Each descriptor holds a control word in bits 31:0 and a buffer address in bits 63:32. In the control word, bits 31:16 are the length, bit 15 is the ownership bit (ready for transmit, empty for receive), bit 14 asks for an interrupt, and bit 13 marks the last entry of a ring.

The controller keeps the current transmit and receive positions. It requests a transmit from the frame engine when the current transmit descriptor is ready to go, and retires that descriptor when the engine reports done. When a received frame arrives, it retires the current receive descriptor. If that descriptor is still full, it raises a busy condition instead. Completion events set sticky interrupt sources, which are masked onto one interrupt line. Software fills and inspects descriptors through a host port.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset the boundary is 0x40, the transmit index is 0, the receive index is 0x40, the interrupt sources are 0, and both `irq` and `tx_start` are low.
- R2: A boundary write of 0x80 or more leaves the boundary unchanged. A write below 0x80 takes effect on the next cycle.
- R3: In the cycle after `tx_en` rises, the transmit index is 0. In the cycle after `rx_en` rises, the receive index equals the boundary. In the rising cycle itself, neither ring starts or accepts anything.
- R4: `tx_start` is high only when all of the following hold:
  - the block is idle;
  - `tx_en` has been high for more than one cycle;
  - the boundary is nonzero;
  - the current descriptor has bit 15 set;
  - the current descriptor's length (bits 31:16) is greater than 4.
- R5: Only one transmit is in flight at a time. `tx_start` stays low until `tx_done` is seen, and `tx_done` has no effect while no transmit is pending.
- R6: After a transmit completes, the transmit index goes to 0 if the descriptor's bit 13 is set. Otherwise it increments, and it returns to 0 when the incremented value reaches the boundary.
- R7: A transmit completion clears bits 15 and 8:0 of the control word and leaves every other bit and the buffer address unchanged. If bit 14 was set, interrupt source bit 0 is set.
- R8: `rx_ready` is high only when `rx_en` has been high for more than one cycle and the boundary is below 0x80. A `rx_valid` pulse while `rx_ready` is low changes nothing.
- R9: If the current receive descriptor has bit 15 clear when a frame arrives, the frame is dropped. Interrupt source bit 4 is set, and both the descriptor and the receive index stay unchanged.
- R10: An accepted frame writes `rx_len` into bits 31:16 and clears bits 15 and 8:0, keeping the other bits. If bit 14 was set, interrupt source bit 2 is set.
- R11: After a receive completion, the receive index returns to the boundary if bit 13 was set or the index was 0x7F. Otherwise it increments.
- R12: `irq` is high when any interrupt source bit is high and its `int_mask` bit is also high. A clear write removes the source bits written as 1. A source bit set by an event in the same cycle as a clear stays set.
- R13: A host write to a descriptor is visible on `host_rdata` from the next cycle. The read port is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | 7 | Host descriptor index |
| host_wdata | input | 64 | Host descriptor write data |
| host_rdata | output | 64 | Descriptor at host_addr |
| bnd_we | input | 1 | Boundary write strobe |
| bnd_wdata | input | 8 | Boundary write value |
| bnd_q | output | 8 | Current boundary |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_start | output | 1 | Transmit request to the frame engine |
| tx_idx | output | 7 | Current transmit descriptor index |
| tx_len | output | 16 | Length field of the current transmit descriptor |
| tx_buf_ptr | output | 32 | Buffer address of the current transmit descriptor |
| tx_done | input | 1 | Frame engine finished the pending transmit |
| rx_valid | input | 1 | A received frame is complete |
| rx_len | input | 16 | Length of the received frame |
| rx_ready | output | 1 | Reception currently allowed |
| rx_idx | output | 7 | Current receive descriptor index |
| rx_buf_ptr | output | 32 | Buffer address of the current receive descriptor |
| int_clr_we | input | 1 | Interrupt source clear strobe |
| int_clr | input | 5 | Source bits to clear |
| int_mask | input | 5 | Interrupt mask |
| int_src | output | 5 | Sticky sources: bit 0 transmit, bit 2 receive, bit 4 busy |
| irq | output | 1 | Interrupt line |

## Verification
The bench shrinks the transmit ring to four entries and sweeps the receive ring across all 124 remaining entries. This checks the wrap at the boundary, the wrap at 0x7F, and the explicit wrap bit. A controller that wrapped one entry early or late would put the next frame at an index other than the one computed in the bench.

The length limit is probed at exactly 4, where a wrong comparison would send a frame. A zero boundary is also probed, where a missing check would send a frame from an empty ring. A completion that arrives together with a clear of the same source bit must leave the bit set, or an interrupt would be lost. A frame arriving on a full descriptor must raise busy without moving the index or writing the descriptor.

// File: rtl/bd_ring_pkg.sv
// Shared constants for the descriptor ring controller.
// Assumes a descriptor control word in bits 31:0 and a buffer address in 63:32.
package bd_ring_pkg;
    localparam int DESC_W    = 64;
    localparam int LEN_W     = 16;
    localparam int LEN_LSB   = 16;
    localparam int OWN_BIT   = 15;
    localparam int IRQ_BIT   = 14;
    localparam int WRAP_BIT  = 13;
    localparam logic [31:0] DONE_CLR_MASK = 32'h0000_81FF;
    localparam int MIN_TX_LEN = 4;
    localparam int INT_W     = 5;
    localparam int INT_TXB   = 0;
    localparam int INT_RXB   = 2;
    localparam int INT_BUSY  = 4;

    typedef enum logic {TX_IDLE = 1'b0, TX_BUSY = 1'b1} tx_state_e;
endpackage

// File: rtl/bd_tx_ctrl.sv
// Transmit ring sequencer: holds the transmit index, decides when a transmit
// may start and advances the index when the frame engine reports done.
// Assumes the caller presents the fields of the descriptors at tx_idx and act_idx.
module bd_tx_ctrl
    import bd_ring_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [IDX_W:0]   bnd,
    input  logic             cur_own,
    input  logic [LEN_W-1:0] cur_len,
    input  logic             act_wrap,
    input  logic             tx_done,
    output logic             tx_start,
    output logic             tx_cmpl,
    output logic [IDX_W-1:0] tx_idx,
    output logic [IDX_W-1:0] act_idx
);
    tx_state_e         st;
    logic              en_q;
    logic              en_rise;
    logic [IDX_W:0]    inc;
    logic [IDX_W-1:0]  nxt;

    assign en_rise  = tx_en && !en_q;
    assign tx_start = (st == TX_IDLE) && tx_en && en_q && (bnd != '0) &&
                      cur_own && (cur_len > LEN_W'(MIN_TX_LEN));
    assign tx_cmpl  = (st == TX_BUSY) && tx_done;
    assign inc      = {1'b0, act_idx} + (IDX_W+1)'(1);
    assign nxt      = (act_wrap || inc >= bnd) ? '0 : inc[IDX_W-1:0];

    // Sequence state, enable history, current and in-flight indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_IDLE;
            en_q    <= 1'b0;
            tx_idx  <= '0;
            act_idx <= '0;
        end else begin
            en_q <= tx_en;
            if (tx_start) begin
                st      <= TX_BUSY;
                act_idx <= tx_idx;
            end else if (tx_cmpl) begin
                st <= TX_IDLE;
            end
            if (en_rise)      tx_idx <= '0;
            else if (tx_cmpl) tx_idx <= nxt;
        end
    end

    a_r5_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_BUSY) |-> !tx_start);
    a_r3_tx_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (tx_idx == '0));
    a_r6_idx_inside_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cmpl && !en_rise) |=> ({1'b0, tx_idx} < $past(bnd) || tx_idx == '0));
endmodule

// File: rtl/bd_rx_ctrl.sv
// Receive ring sequencer: holds the receive index, tells whether reception
// is allowed and classifies an arriving frame as accepted or dropped busy.
// Assumes the caller presents the fields of the descriptor at rx_idx.
module bd_rx_ctrl #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [IDX_W:0]   bnd,
    input  logic             rx_valid,
    input  logic             cur_empty,
    input  logic             cur_wrap,
    output logic             rx_ok,
    output logic             rx_cmpl,
    output logic             rx_busy,
    output logic [IDX_W-1:0] rx_idx
);
    localparam int NUM_DESC = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_DESC - 1);
    localparam logic [IDX_W-1:0] RST_IDX   = IDX_W'(NUM_DESC / 2);

    logic              en_q;
    logic              en_rise;
    logic              take;
    logic [IDX_W-1:0]  nxt;

    assign en_rise = rx_en && !en_q;
    assign rx_ok   = rx_en && en_q && (bnd < (IDX_W+1)'(NUM_DESC));
    assign take    = rx_valid && rx_ok;
    assign rx_cmpl = take && cur_empty;
    assign rx_busy = take && !cur_empty;
    assign nxt     = (cur_wrap || rx_idx == LAST_IDX) ? bnd[IDX_W-1:0] : rx_idx + 1'b1;

    // Enable history and receive index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rx_idx <= RST_IDX;
        end else begin
            en_q <= rx_en;
            if (en_rise)      rx_idx <= bnd[IDX_W-1:0];
            else if (rx_cmpl) rx_idx <= nxt;
        end
    end

    a_r3_rx_rise_loads: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (rx_idx == $past(bnd[IDX_W-1:0])));
    a_r9_busy_holds_idx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> $stable(rx_idx));
    a_r8_no_take_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !(rx_cmpl || rx_busy));
endmodule

// File: rtl/bd_irq_ctrl.sv
// Sticky interrupt sources with write-one-to-clear and a mask onto one line.
// Assumes set events are single-cycle; a set wins over a clear in one cycle.
module bd_irq_ctrl #(
    parameter int INT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] set_vec,
    input  logic             clr_we,
    input  logic [INT_W-1:0] clr_vec,
    input  logic [INT_W-1:0] mask,
    output logic [INT_W-1:0] src,
    output logic             irq
);
    logic [INT_W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_vec : '0;
    assign irq     = |(src & mask);

    // Source register: clear then set.
    always_ff @(posedge clk) begin
        if (!rst_n) src <= '0;
        else        src <= (src & ~clr_eff) | set_vec;
    end

    a_r12_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((src & $past(clr_vec) & ~$past(set_vec)) == '0));
    a_r12_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((src & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/bd_ring_ctrl.sv
// Descriptor ring controller top: owns the descriptor table and the boundary
// register, and joins the transmit, receive and interrupt sequencers.
// Assumes the host does not rewrite a descriptor in the cycle it completes.
module bd_ring_ctrl
    import bd_ring_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [DESC_W-1:0] host_wdata,
    output logic [DESC_W-1:0] host_rdata,
    input  logic              bnd_we,
    input  logic [IDX_W:0]    bnd_wdata,
    output logic [IDX_W:0]    bnd_q,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic              tx_start,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [LEN_W-1:0]  tx_len,
    output logic [31:0]       tx_buf_ptr,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              rx_ready,
    output logic [IDX_W-1:0]  rx_idx,
    output logic [31:0]       rx_buf_ptr,
    input  logic              int_clr_we,
    input  logic [INT_W-1:0]  int_clr,
    input  logic [INT_W-1:0]  int_mask,
    output logic [INT_W-1:0]  int_src,
    output logic              irq
);
    localparam int NUM_DESC = 1 << IDX_W;
    localparam logic [IDX_W:0] BND_RST = (IDX_W+1)'(NUM_DESC / 2);

    logic [DESC_W-1:0] tbl [NUM_DESC];
    logic [DESC_W-1:0] tx_word, act_word, rx_word;
    logic [IDX_W-1:0]  act_idx;
    logic              tx_cmpl, rx_cmpl, rx_busy;
    logic [INT_W-1:0]  set_vec;

    assign tx_word    = tbl[tx_idx];
    assign act_word   = tbl[act_idx];
    assign rx_word    = tbl[rx_idx];
    assign host_rdata = tbl[host_addr];
    assign tx_len     = tx_word[LEN_LSB +: LEN_W];
    assign tx_buf_ptr = tx_word[63:32];
    assign rx_buf_ptr = rx_word[63:32];

    // Boundary register: out-of-range writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          bnd_q <= BND_RST;
        else if (bnd_we && bnd_wdata < (IDX_W+1)'(NUM_DESC)) bnd_q <= bnd_wdata;
    end

    // Descriptor table: host writes, then completion write-backs.
    always_ff @(posedge clk) begin
        if (host_we) tbl[host_addr] <= host_wdata;
        if (tx_cmpl) tbl[act_idx][31:0] <= act_word[31:0] & ~DONE_CLR_MASK;
        if (rx_cmpl) tbl[rx_idx][31:0] <= {rx_len, rx_word[15:0] & ~DONE_CLR_MASK[15:0]};
    end

    // Interrupt set events from both rings.
    always_comb begin
        set_vec           = '0;
        set_vec[INT_TXB]  = tx_cmpl && act_word[IRQ_BIT];
        set_vec[INT_RXB]  = rx_cmpl && rx_word[IRQ_BIT];
        set_vec[INT_BUSY] = rx_busy;
    end

    bd_tx_ctrl #(.IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bnd(bnd_q),
        .cur_own(tx_word[OWN_BIT]), .cur_len(tx_word[LEN_LSB +: LEN_W]),
        .act_wrap(act_word[WRAP_BIT]), .tx_done(tx_done),
        .tx_start(tx_start), .tx_cmpl(tx_cmpl), .tx_idx(tx_idx), .act_idx(act_idx)
    );

    bd_rx_ctrl #(.IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bnd(bnd_q), .rx_valid(rx_valid),
        .cur_empty(rx_word[OWN_BIT]), .cur_wrap(rx_word[WRAP_BIT]),
        .rx_ok(rx_ready), .rx_cmpl(rx_cmpl), .rx_busy(rx_busy), .rx_idx(rx_idx)
    );

    bd_irq_ctrl #(.INT_W(INT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(int_clr_we),
        .clr_vec(int_clr), .mask(int_mask), .src(int_src), .irq(irq)
    );

    a_r2_reject_high_bnd: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_we && bnd_wdata >= (IDX_W+1)'(NUM_DESC)) |=> $stable(bnd_q));
    a_r7_tx_owner_released: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cmpl && !(host_we && host_addr == act_idx)) |=> !tbl[$past(act_idx)][OWN_BIT]);
endmodule

// File: tb/bd_ring_ctrl_tb_top.sv
// Self-checking bench: small transmit ring of four, full sweep of the receive ring.
module bd_ring_ctrl_tb_top;
    localparam int IDX_W = 7;
    localparam int NUM   = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        bnd_we = 1'b0;
    logic [7:0]  bnd_wdata = '0;
    logic [7:0]  bnd_q;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        tx_start;
    logic [6:0]  tx_idx;
    logic [15:0] tx_len;
    logic [31:0] tx_buf_ptr;
    logic        tx_done = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_len = '0;
    logic        rx_ready;
    logic [6:0]  rx_idx;
    logic [31:0] rx_buf_ptr;
    logic        int_clr_we = 1'b0;
    logic [4:0]  int_clr = '0;
    logic [4:0]  int_mask = '0;
    logic [4:0]  int_src;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bd_ring_ctrl #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bnd_we(bnd_we),
        .bnd_wdata(bnd_wdata), .bnd_q(bnd_q), .tx_en(tx_en), .rx_en(rx_en),
        .tx_start(tx_start), .tx_idx(tx_idx), .tx_len(tx_len), .tx_buf_ptr(tx_buf_ptr),
        .tx_done(tx_done), .rx_valid(rx_valid), .rx_len(rx_len), .rx_ready(rx_ready),
        .rx_idx(rx_idx), .rx_buf_ptr(rx_buf_ptr), .int_clr_we(int_clr_we),
        .int_clr(int_clr), .int_mask(int_mask), .int_src(int_src), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic hw(input int a, input logic [63:0] d);
        host_we = 1'b1; host_addr = 7'(a); host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        host_addr = 7'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic setbnd(input logic [7:0] v);
        bnd_we = 1'b1; bnd_wdata = v;
        tick();
        bnd_we = 1'b0;
    endtask

    task automatic clr_all();
        int_clr_we = 1'b1; int_clr = 5'h1F;
        tick();
        int_clr_we = 1'b0; int_clr = '0;
    endtask

    // Arm one transmit descriptor, serve it as the frame engine, check results.
    task automatic tx_serve(input int exp_idx, input logic [31:0] flags, input logic [31:0] ptr,
                            input bit clr_same);
        logic [63:0] d;
        hw(exp_idx, {ptr, flags});
        #1;
        chk(tx_start == 1'b1, "R4 start when ready", 64'(tx_start), 64'd1);
        chk(tx_idx == 7'(exp_idx), "R6 tx index", 64'(tx_idx), 64'(exp_idx));
        chk(tx_len == flags[31:16] && tx_buf_ptr == ptr, "R4 tx fields",
            {tx_len, 16'h0, tx_buf_ptr}, {flags[31:16], 16'h0, ptr});
        tick();
        #1;
        chk(tx_start == 1'b0, "R5 no second start", 64'(tx_start), 64'd0);
        tx_done = 1'b1;
        if (clr_same) begin int_clr_we = 1'b1; int_clr = 5'h01; end
        tick();
        tx_done = 1'b0; int_clr_we = 1'b0; int_clr = '0;
        rd(exp_idx, d);
        chk(d == {ptr, flags & ~32'h81FF}, "R7 tx write-back", d, {ptr, flags & ~32'h81FF});
        chk(int_src == {4'h0, flags[14]}, "R7 R12 tx source", 64'(int_src), 64'(flags[14]));
        clr_all();
    endtask

    task automatic rx_frame(input int exp_idx, input logic [15:0] len);
        #1;
        chk(rx_idx == 7'(exp_idx), "R11 rx index", 64'(rx_idx), 64'(exp_idx));
        chk(rx_ready == 1'b1, "R8 rx ready", 64'(rx_ready), 64'd1);
        rx_valid = 1'b1; rx_len = len;
        tick();
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d, d0;
        int exp_i;
        logic [31:0] fl;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(bnd_q == 8'h40, "R1 boundary", 64'(bnd_q), 64'h40);
        chk(tx_idx == 0, "R1 tx index", 64'(tx_idx), 64'h0);
        chk(rx_idx == 7'h40, "R1 rx index", 64'(rx_idx), 64'h40);
        chk(int_src == 0 && irq == 0 && tx_start == 0, "R1 sources",
            {int_src, irq, tx_start}, 64'h0);
        tick();

        // R13 fill the table, verify readback
        for (int i = 0; i < NUM; i++) hw(i, 64'h0);
        hw(9, 64'hDEAD_0009_0055_1234);
        rd(9, d);
        chk(d == 64'hDEAD_0009_0055_1234, "R13 host readback", d, 64'hDEAD_0009_0055_1234);
        hw(9, 64'h0);

        // R2 boundary range
        setbnd(8'h80); #1;
        chk(bnd_q == 8'h40, "R2 reject 0x80", 64'(bnd_q), 64'h40);
        setbnd(8'hFF); #1;
        chk(bnd_q == 8'h40, "R2 reject 0xFF", 64'(bnd_q), 64'h40);
        setbnd(8'h04); #1;
        chk(bnd_q == 8'h04, "R2 accept 4", 64'(bnd_q), 64'h04);

        // R3 tx enable rise, R4 negative cases
        tx_en = 1'b1; #1;
        chk(tx_start == 0, "R3 no start in rise cycle", 64'(tx_start), 64'h0);
        tick();
        hw(0, {32'h100, 16'd4, 16'h8000}); #1;
        chk(tx_start == 0, "R4 length 4 blocked", 64'(tx_start), 64'h0);
        hw(0, {32'h100, 16'd60, 16'h0000}); #1;
        chk(tx_start == 0, "R4 not ready blocked", 64'(tx_start), 64'h0);
        setbnd(8'h00);
        hw(0, {32'h100, 16'd60, 16'h8000}); #1;
        chk(tx_start == 0, "R4 empty ring blocked", 64'(tx_start), 64'h0);
        hw(0, 64'h0);
        setbnd(8'h04);

        // R5 done while idle is ignored
        tx_done = 1'b1; tick(); tx_done = 1'b0; #1;
        chk(tx_idx == 0 && int_src == 0, "R5 idle done ignored", {tx_idx, int_src}, 64'h0);

        // R6 R7 transmit sweep over a four-entry ring
        exp_i = 0;
        for (int k = 0; k < 9; k++) begin
            fl = {16'(20 + k), 1'b1, 1'(k % 2 == 0), 1'(k == 5), 13'h1BFF};
            tx_serve(exp_i, fl, 32'h4000 + 32'(k), k == 4);
            if (fl[13] || exp_i + 1 >= 4) exp_i = 0; else exp_i = exp_i + 1;
            #1;
            chk(tx_idx == 7'(exp_i), "R6 tx advance", 64'(tx_idx), 64'(exp_i));
        end

        // R4 disabled, then R3 rise clears a nonzero index
        tx_en = 1'b0; tick();
        hw(exp_i, {32'h7, 16'd30, 16'h8000}); #1;
        chk(tx_start == 0, "R4 disabled blocked", 64'(tx_start), 64'h0);
        hw(exp_i, 64'h0);
        tx_en = 1'b1; tick(); #1;
        chk(tx_idx == 0, "R3 tx index cleared", 64'(tx_idx), 64'h0);

        // R3 R8 receive enable
        for (int i = 4; i < NUM; i++)
            hw(i, {32'h2000 + 32'(i), 16'h0, 1'b1, 1'(i % 3 == 0), 1'b0, 13'h11FF});
        rx_en = 1'b1; #1;
        chk(rx_ready == 0, "R8 not ready in rise cycle", 64'(rx_ready), 64'h0);
        tick(); #1;
        chk(rx_idx == 4, "R3 rx index loaded", 64'(rx_idx), 64'h4);

        // R10 R11 sweep the whole receive ring
        exp_i = 4;
        for (int k = 0; k < NUM - 4; k++) begin
            rd(exp_i, d0);
            chk(rx_buf_ptr == d0[63:32], "R11 rx pointer", 64'(rx_buf_ptr), 64'(d0[63:32]));
            rx_frame(exp_i, 16'(64 + k));
            rd(exp_i, d);
            chk(d == {d0[63:32], 16'(64 + k), d0[15:0] & ~16'h81FF}, "R10 rx write-back",
                d, {d0[63:32], 16'(64 + k), d0[15:0] & ~16'h81FF});
            chk(int_src == {2'b0, d0[14], 2'b0}, "R10 rx source", 64'(int_src), 64'({d0[14], 2'b0}));
            clr_all();
            exp_i = (exp_i == NUM - 1) ? 4 : exp_i + 1;
        end
        #1;
        chk(rx_idx == 4, "R11 wrap at last entry", 64'(rx_idx), 64'h4);

        // R11 wrap bit
        hw(4, {32'h3000, 16'h0, 16'h8000});
        hw(5, {32'h3001, 16'h0, 16'hA000});
        rx_frame(4, 16'd70);
        rx_frame(5, 16'd71);
        #1;
        chk(rx_idx == 4, "R11 wrap bit", 64'(rx_idx), 64'h4);
        clr_all();

        // R9 full descriptor drops the frame
        rd(4, d0);
        rx_frame(4, 16'd99);
        rd(4, d);
        chk(d == d0, "R9 descriptor untouched", d, d0);
        chk(rx_idx == 4 && int_src == 5'h10, "R9 busy source", {rx_idx, int_src}, {7'h4, 5'h10});

        // R12 masking and clearing
        int_mask = 5'h00; #1;
        chk(irq == 0, "R12 masked off", 64'(irq), 64'h0);
        int_mask = 5'h01; #1;
        chk(irq == 0, "R12 other bit", 64'(irq), 64'h0);
        int_mask = 5'h10; #1;
        chk(irq == 1, "R12 unmasked", 64'(irq), 64'h1);
        int_clr_we = 1'b1; int_clr = 5'h10; tick(); int_clr_we = 1'b0; #1;
        chk(int_src == 0 && irq == 0, "R12 clear", {int_src, irq}, 64'h0);

        // R8 disabled reception ignores frames
        rx_en = 1'b0; tick();
        hw(4, {32'h3000, 16'h0, 16'h8000});
        #1;
        chk(rx_ready == 0, "R8 ready low", 64'(rx_ready), 64'h0);
        rx_valid = 1'b1; rx_len = 16'd5; tick(); rx_valid = 1'b0;
        rd(4, d);
        chk(d == {32'h3000, 16'h0, 16'h8000} && rx_idx == 4 && int_src == 0, "R8 frame ignored",
            d, {32'h3000, 16'h0, 16'h8000});

        // R3 reload follows a new boundary
        setbnd(8'h08);
        rx_en = 1'b1; tick(); #1;
        chk(rx_idx == 8, "R3 rx reload new boundary", 64'(rx_idx), 64'h8);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule